// File: doc/BRIEF.md
# Adaptive Redundancy Mode Sequencer

This block steers a processing system between two protection modes. A run starts in triple modular redundancy, where three copies execute in lockstep and vote. The block counts instructions that retire without a redundancy error. When that clean count reaches a programmable threshold, it latches a permanent switch into temporal duplicate-and-compare mode (TSR). Any error seen in triple mode restarts the count, so the switch point moves later in the program. If the program ends before the count reaches the threshold, the run stays in triple mode to the end.

In TSR mode the block schedules checkpoints. A checkpoint is requested only when the loop counter steps forward onto one of a fixed set of milestones (multiples of a parameterised step). Checkpoints alternate between two memory segments. The first one after the mode switch always targets segment 1. The loop counter is the last item written in a checkpoint, and the block compares it with its duplicate. A mismatch produces a single rollback pulse and names the segment that holds the newest committed checkpoint. It also abandons any checkpoint still in progress, so the next attempt writes to the same segment again.

Top module: `redund_mode_seq`

## Requirements
- R1: After reset the block is in triple mode (`mode_tsr`=0), `ckpt_req`=0, `rollback`=0, `ckpt_seg`=1 and `restore_seg`=0.
- R2: A retire with no error that brings the clean count to the threshold sets `mode_tsr` to 1 on the following cycle. `mode_tsr` only rises after such a retire and stays set until `run_start`.
- R3: `tmr_err` resets the clean count to zero. A retire in the same cycle as `tmr_err` is not counted.
- R4: `thresh_wr` loads `thresh_val` as the new threshold, and it is used from the next cycle on. A threshold of 0 acts as 1.
- R5: Once `prog_end` is seen, no mode switch happens for the rest of the run, including on the retire that carries `prog_end`. `run_start` returns the block to the R1 state, clears the count and ends this block.
- R6: In TSR mode, `ckpt_req` rises on the cycle after `loop_cnt` advances by exactly one onto k*STEP (k = 1..NUM_MILES). It never rises in triple mode. It does not rise when `loop_cnt` jumps onto a milestone by any other step, as happens on a restore.
- R7: The first checkpoint after the mode switch targets segment 1. `ckpt_seg` holds steady while `ckpt_req` is high.
- R8: `ckpt_done` while `ckpt_req` is high, with `loop_cnt` equal to `loop_dup`, commits the checkpoint. On the next cycle `ckpt_req` falls, `ckpt_seg` toggles and `restore_seg` takes the committed segment.
- R9: In TSR mode, the first cycle in which `loop_cnt` differs from `loop_dup` gives a one-cycle `rollback` on the next cycle. It also drops `ckpt_req` and leaves `ckpt_seg` and `restore_seg` unchanged. A mismatch in triple mode is ignored.
- R10: `tmr_err` in TSR mode has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thresh_wr | input | 1 | Load strobe for the clean-instruction threshold |
| thresh_val | input | IW | New threshold value |
| run_start | input | 1 | Start of a new program run |
| instr_ret | input | 1 | One instruction retired this cycle |
| tmr_err | input | 1 | Redundancy error detected in triple mode |
| prog_end | input | 1 | The program has reached its end |
| loop_cnt | input | LW | Loop counter |
| loop_dup | input | LW | Duplicate loop counter |
| ckpt_done | input | 1 | Checkpoint write sequence finished |
| mode_tsr | output | 1 | 0 = triple mode, 1 = temporal mode |
| ckpt_req | output | 1 | Checkpoint creation request |
| ckpt_seg | output | 1 | Segment targeted by the checkpoint |
| rollback | output | 1 | One-cycle rollback request |
| restore_seg | output | 1 | Segment holding the newest committed checkpoint |

## Verification
The bench builds the block with STEP=4, NUM_MILES=3, a 6-bit loop counter and an 8-bit instruction count. With these values, milestones at 4, 8 and 12 are reached in a handful of loop steps, and a retried checkpoint after a rollback fits in a short vector table. The threshold is written to 3 at run time and later to 0. This lets error restarts, the end-of-program block and the zero-threshold case each play out within a few retires.

// File: rtl/rms_pkg.sv
package rms_pkg;

    typedef enum logic {
        MODE_TMR = 1'b0,
        MODE_TSR = 1'b1
    } rms_mode_e;

    typedef struct packed {
        rms_mode_e mode;
        logic      ended;
    } rms_top_state_t;

    typedef struct packed {
        logic req;
        logic seg;
        logic commit;
        logic mis;
        logic rb;
    } rms_ckpt_state_t;

endpackage

// File: rtl/rms_clean_counter.sv
module rms_clean_counter #(
    parameter int IW         = 16,
    parameter int DEF_THRESH = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          thresh_wr,
    input  logic [IW-1:0] thresh_val,
    input  logic          clear,
    input  logic          retire,
    input  logic          err,
    output logic          reach
);
    localparam logic [IW-1:0] CNT_MAX = {IW{1'b1}};

    typedef struct packed {
        logic [IW-1:0] cnt;
        logic [IW-1:0] thresh;
    } cnt_state_t;

    cnt_state_t st_q, st_d;
    logic [IW:0] cnt_inc;

    always_comb begin
        st_d    = st_q;
        cnt_inc = {1'b0, st_q.cnt} + (IW+1)'(1);
        reach   = retire && !err && !clear && (cnt_inc >= {1'b0, st_q.thresh});
        if (thresh_wr) begin
            st_d.thresh = thresh_val;
        end
        if (clear || err) begin
            st_d.cnt = '0;
        end else if (retire && (st_q.cnt != CNT_MAX)) begin
            st_d.cnt = cnt_inc[IW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt    <= '0;
            st_q.thresh <= IW'(DEF_THRESH);
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rms_milestone.sv
module rms_milestone #(
    parameter int LW        = 10,
    parameter int STEP      = 250,
    parameter int NUM_MILES = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] loop_cnt,
    output logic          hit
);
    logic [LW-1:0]        prev_q, prev_d;
    logic [NUM_MILES-1:0] at_mile;
    logic                 fwd_step;

    for (genvar k = 0; k < NUM_MILES; k++) begin : g_mile
        assign at_mile[k] = (loop_cnt == LW'((k + 1) * STEP));
    end

    always_comb begin
        prev_d   = loop_cnt;
        fwd_step = (loop_cnt == prev_q + LW'(1));
        hit      = fwd_step && (|at_mile);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/rms_ckpt_ctl.sv
module rms_ckpt_ctl
    import rms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic enter,
    input  logic tsr,
    input  logic hit,
    input  logic done,
    input  logic mismatch,
    output logic req,
    output logic seg,
    output logic commit,
    output logic rb
);
    rms_ckpt_state_t st_q, st_d;
    logic mis_rise;

    always_comb begin
        st_d     = st_q;
        mis_rise = tsr && mismatch && !st_q.mis;
        st_d.rb  = 1'b0;
        st_d.mis = tsr && mismatch;
        if (restart || enter) begin
            st_d.req    = 1'b0;
            st_d.seg    = 1'b1;
            st_d.commit = 1'b0;
            st_d.mis    = 1'b0;
        end else if (tsr) begin
            if (mis_rise) begin
                st_d.rb  = 1'b1;
                st_d.req = 1'b0;
            end else if (st_q.req && done) begin
                st_d.req    = 1'b0;
                st_d.commit = st_q.seg;
                st_d.seg    = ~st_q.seg;
            end else if (!st_q.req && hit) begin
                st_d.req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{req: 1'b0, seg: 1'b1, commit: 1'b0, mis: 1'b0, rb: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req    = st_q.req;
    assign seg    = st_q.seg;
    assign commit = st_q.commit;
    assign rb     = st_q.rb;
endmodule

// File: rtl/redund_mode_seq.sv
module redund_mode_seq
    import rms_pkg::*;
#(
    parameter int IW         = 16,
    parameter int LW         = 10,
    parameter int STEP       = 250,
    parameter int NUM_MILES  = 3,
    parameter int DEF_THRESH = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          thresh_wr,
    input  logic [IW-1:0] thresh_val,
    input  logic          run_start,
    input  logic          instr_ret,
    input  logic          tmr_err,
    input  logic          prog_end,
    input  logic [LW-1:0] loop_cnt,
    input  logic [LW-1:0] loop_dup,
    input  logic          ckpt_done,
    output logic          mode_tsr,
    output logic          ckpt_req,
    output logic          ckpt_seg,
    output logic          rollback,
    output logic          restore_seg
);
    rms_top_state_t st_q, st_d;
    logic reach, hit, switch_now, in_tsr, mismatch;

    rms_clean_counter #(.IW(IW), .DEF_THRESH(DEF_THRESH)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .thresh_wr (thresh_wr),
        .thresh_val(thresh_val),
        .clear     (run_start),
        .retire    (instr_ret),
        .err       (tmr_err),
        .reach     (reach)
    );

    rms_milestone #(.LW(LW), .STEP(STEP), .NUM_MILES(NUM_MILES)) u_mile (
        .clk     (clk),
        .rst_n   (rst_n),
        .loop_cnt(loop_cnt),
        .hit     (hit)
    );

    always_comb begin
        st_d       = st_q;
        in_tsr     = (st_q.mode == MODE_TSR);
        mismatch   = (loop_cnt != loop_dup);
        switch_now = !in_tsr && reach && !st_q.ended && !prog_end && !run_start;
        if (run_start) begin
            st_d.mode  = MODE_TMR;
            st_d.ended = 1'b0;
        end else begin
            st_d.ended = st_q.ended | prog_end;
            if (switch_now) begin
                st_d.mode = MODE_TSR;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_TMR, ended: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    rms_ckpt_ctl u_ckpt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (run_start),
        .enter   (switch_now),
        .tsr     (in_tsr),
        .hit     (hit),
        .done    (ckpt_done),
        .mismatch(mismatch),
        .req     (ckpt_req),
        .seg     (ckpt_seg),
        .commit  (restore_seg),
        .rb      (rollback)
    );

    assign mode_tsr = in_tsr;
endmodule

// File: rtl/rms_checker.sv
module rms_checker #(
    parameter int LW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run_start,
    input logic          instr_ret,
    input logic          tmr_err,
    input logic          prog_end,
    input logic [LW-1:0] loop_cnt,
    input logic [LW-1:0] loop_dup,
    input logic          ckpt_done,
    input logic          mode_tsr,
    input logic          ckpt_req,
    input logic          ckpt_seg,
    input logic          rollback,
    input logic          restore_seg
);
    // R2
    mode_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_tsr) |-> ($past(instr_ret) && !$past(tmr_err) && !$past(prog_end)));

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mode_tsr) |-> $past(run_start));

    // R6
    req_in_tsr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_req |-> mode_tsr);

    // R7
    seg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_req && !ckpt_done && !run_start) |=> (!ckpt_req || $stable(ckpt_seg)));

    // R8
    commit_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ckpt_req && ckpt_done && !run_start && (loop_cnt == loop_dup))
        |=> ((ckpt_seg != $past(ckpt_seg)) && (restore_seg == $past(ckpt_seg)) && !ckpt_req));

    // R9
    rollback_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |-> ($past(mode_tsr) && ($past(loop_cnt) != $past(loop_dup))));

    // R9
    rollback_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |=> !rollback);

    // R9
    rollback_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rollback |-> ($stable(ckpt_seg) && $stable(restore_seg) && !ckpt_req));
endmodule

bind redund_mode_seq rms_checker #(.LW(LW)) u_rms_chk (.*);

// File: tb/redund_mode_seq_test.sv
module redund_mode_seq_test;
    localparam int IW = 8;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          thresh_wr = 1'b0;
    logic [IW-1:0] thresh_val = '0;
    logic          run_start = 1'b0;
    logic          instr_ret = 1'b0;
    logic          tmr_err = 1'b0;
    logic          prog_end = 1'b0;
    logic [LW-1:0] loop_cnt = '0;
    logic [LW-1:0] loop_dup = '0;
    logic          ckpt_done = 1'b0;
    logic          mode_tsr, ckpt_req, ckpt_seg, rollback, restore_seg;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    redund_mode_seq #(.IW(IW), .LW(LW), .STEP(4), .NUM_MILES(3), .DEF_THRESH(5)) uut (
        .clk(clk), .rst_n(rst_n), .thresh_wr(thresh_wr), .thresh_val(thresh_val),
        .run_start(run_start), .instr_ret(instr_ret), .tmr_err(tmr_err),
        .prog_end(prog_end), .loop_cnt(loop_cnt), .loop_dup(loop_dup),
        .ckpt_done(ckpt_done), .mode_tsr(mode_tsr), .ckpt_req(ckpt_req),
        .ckpt_seg(ckpt_seg), .rollback(rollback), .restore_seg(restore_seg)
    );

    // {run_start, instr_ret, tmr_err, prog_end, ckpt_done}, loop_cnt, loop_dup,
    // expected {mode, req, seg, rollback, restore_seg}, requirement number
    localparam int NV = 43;
    localparam logic [25:0] VEC [0:NV-1] = '{
        {5'b01000, 6'd0, 6'd0, 5'b00100, 4'd2},  // R2 count 1
        {5'b01000, 6'd0, 6'd0, 5'b00100, 4'd2},  // R2 count 2
        {5'b00100, 6'd0, 6'd0, 5'b00100, 4'd3},  // R3 error clears
        {5'b01100, 6'd0, 6'd0, 5'b00100, 4'd3},  // R3 retire with error not counted
        {5'b01000, 6'd0, 6'd0, 5'b00100, 4'd3},  // R3 count 1
        {5'b00000, 6'd3, 6'd3, 5'b00100, 4'd6},
        {5'b00000, 6'd4, 6'd4, 5'b00100, 4'd6},  // R6 milestone in triple mode
        {5'b00000, 6'd4, 6'd7, 5'b00100, 4'd9},  // R9 mismatch ignored in triple mode
        {5'b00000, 6'd0, 6'd0, 5'b00100, 4'd9},
        {5'b01000, 6'd0, 6'd0, 5'b00100, 4'd2},  // R2 count 2
        {5'b01000, 6'd0, 6'd0, 5'b10100, 4'd2},  // R2 count 3 switches
        {5'b00100, 6'd0, 6'd0, 5'b10100, 4'd10}, // R10 error in TSR
        {5'b00000, 6'd1, 6'd1, 5'b10100, 4'd6},
        {5'b00000, 6'd2, 6'd2, 5'b10100, 4'd6},
        {5'b00000, 6'd3, 6'd3, 5'b10100, 4'd6},
        {5'b00000, 6'd4, 6'd4, 5'b11100, 4'd7},  // R7 first request to segment 1
        {5'b00000, 6'd4, 6'd4, 5'b11100, 4'd7},  // R7 held
        {5'b00001, 6'd4, 6'd4, 5'b10001, 4'd8},  // R8 commit
        {5'b00000, 6'd5, 6'd5, 5'b10001, 4'd6},
        {5'b00000, 6'd6, 6'd6, 5'b10001, 4'd6},
        {5'b00000, 6'd7, 6'd7, 5'b10001, 4'd6},
        {5'b00000, 6'd8, 6'd8, 5'b11001, 4'd6},  // R6 second milestone
        {5'b00001, 6'd8, 6'd6, 5'b10011, 4'd9},  // R9 mismatch at done
        {5'b00000, 6'd8, 6'd6, 5'b10001, 4'd9},  // R9 single pulse
        {5'b00000, 6'd4, 6'd4, 5'b10001, 4'd6},  // R6 restore jump, no request
        {5'b00000, 6'd5, 6'd5, 5'b10001, 4'd6},
        {5'b00000, 6'd6, 6'd6, 5'b10001, 4'd6},
        {5'b00000, 6'd7, 6'd7, 5'b10001, 4'd6},
        {5'b00000, 6'd8, 6'd8, 5'b11001, 4'd9},  // R9 retry same segment
        {5'b00001, 6'd8, 6'd8, 5'b10100, 4'd8},  // R8 commit segment 0
        {5'b00000, 6'd9, 6'd9, 5'b10100, 4'd8},
        {5'b00000, 6'd9, 6'd2, 5'b10110, 4'd9},  // R9 mismatch outside checkpoint
        {5'b00000, 6'd9, 6'd2, 5'b10100, 4'd9},
        {5'b00000, 6'd9, 6'd9, 5'b10100, 4'd9},
        {5'b10000, 6'd9, 6'd9, 5'b00100, 4'd5},  // R5 run start
        {5'b01000, 6'd9, 6'd9, 5'b00100, 4'd5},
        {5'b01000, 6'd9, 6'd9, 5'b00100, 4'd5},
        {5'b01010, 6'd9, 6'd9, 5'b00100, 4'd5},  // R5 end blocks the reaching retire
        {5'b01000, 6'd9, 6'd9, 5'b00100, 4'd5},  // R5 stays blocked
        {5'b10000, 6'd9, 6'd9, 5'b00100, 4'd5},
        {5'b01000, 6'd9, 6'd9, 5'b00100, 4'd5},
        {5'b01000, 6'd9, 6'd9, 5'b00100, 4'd5},
        {5'b01000, 6'd9, 6'd9, 5'b10100, 4'd5}   // R5 new run switches again
    };

    task automatic check(input logic [4:0] exp, input int req);
        logic [4:0] act;
        act = {mode_tsr, ckpt_req, ckpt_seg, rollback, restore_seg};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d: outputs %b expected %b", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state
        check(5'b00100, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(5'b00100, 1);
        // R4 program threshold 3
        thresh_wr  = 1'b1;
        thresh_val = 8'd3;
        @(negedge clk);
        thresh_wr = 1'b0;
        for (int i = 0; i < NV; i++) begin
            {run_start, instr_ret, tmr_err, prog_end, ckpt_done} = VEC[i][25:21];
            loop_cnt = VEC[i][20:15];
            loop_dup = VEC[i][14:9];
            @(negedge clk);
            check(VEC[i][8:4], int'(VEC[i][3:0]));
        end
        {run_start, instr_ret, tmr_err, prog_end, ckpt_done} = 5'b0;
        // R4 threshold 0 behaves as 1
        run_start  = 1'b1;
        thresh_wr  = 1'b1;
        thresh_val = 8'd0;
        @(negedge clk);
        run_start = 1'b0;
        thresh_wr = 1'b0;
        check(5'b00100, 4);
        instr_ret = 1'b1;
        @(negedge clk);
        instr_ret = 1'b0;
        check(5'b10100, 4);
        // R1 asynchronous reset returns to the initial state
        rst_n = 1'b0;
        #1;
        check(5'b00100, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule